// File: doc/BRIEF.md
# Processor Special Cycle Decoder

This block sits on the system side of a 64-bit-data processor bus. It watches every address strobe. When the strobe comes with the qualifier combination that marks a special bus cycle, it works out which special cycle the processor is running. It then always ends that cycle with a single-clock ready strobe. In the same clock as the ready strobe it raises one event pulse that names the cycle: halt, shutdown, stop grant, flush acknowledge, writeback or cache flush. Any special cycle whose encoding it does not recognise gets an "unknown" pulse instead, and that cycle is still terminated.

The number of wait clocks before the ready strobe can be chosen per cycle from 0 to 3. A shutdown cycle also sets a sticky flag. The flag tells the system that the processor has stopped after a triple fault and must be released. It stays set until a non-maskable interrupt, an initialisation request, a system-management interrupt or a reset is seen. Ordinary memory and I/O traffic is ignored.

Top module: `spc_cycle_watch`

## Requirements
- R1: A cycle is accepted only at a rising edge where ads_n=0, dc_n=0, mio_n=0 and wr_n=1. Any other combination produces no ready strobe and no event.
- R2: Byte enables be_n=8'hFB with addr[4:3]=2'b00 decode as halt. The same be_n=8'hFB with addr[4:3]=2'b10 decodes as stop grant.
- R3: be_n=8'hEF decodes as flush acknowledge, 8'hF7 as writeback and 8'hFD as cache flush, each only with addr[4:3]=2'b00.
- R4: be_n=8'hFE with addr[4:3]=2'b00 decodes as shutdown.
- R5: A special cycle whose byte enables or addr[4:3] match none of the encodings above, or whose addr[31:5] is not all zero, raises ev_unknown.
- R6: The wait count W on wait_cfg is sampled at the accepting edge, which counts as edge 0. brdy_n is then low for exactly the one clock that follows edge W, and high otherwise.
- R7: Every accepted special cycle produces exactly one event output high, for one clock, in the same clock that brdy_n is low. No event is high while brdy_n is high.
- R8: An address strobe seen while a cycle is waiting for its ready strobe, or in the clock where brdy_n is low, is ignored.
- R9: shutdown_flag goes high in the clock of ev_shutdown. It stays high until an edge samples nmi=1, init=1 or smi_n=0. If such a release input arrives at the same edge that issues the shutdown pulse, the flag still sets.
- R10: A synchronous active-high rst forces brdy_n=1, all events to 0 and shutdown_flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ads_n | input | 1 | Address strobe, active low |
| dc_n | input | 1 | Data/code qualifier (0 for special cycles) |
| mio_n | input | 1 | Memory/IO qualifier (0 for special cycles) |
| wr_n | input | 1 | Write/read qualifier (1 for special cycles) |
| be_n | input | 8 | Active-low byte enables |
| addr | input | 29 | Address bits 31:3 |
| wait_cfg | input | 2 | Wait clocks before ready, sampled with the strobe |
| nmi | input | 1 | Non-maskable interrupt, releases shutdown |
| init | input | 1 | Initialisation request, releases shutdown |
| smi_n | input | 1 | System-management interrupt, active low, releases shutdown |
| brdy_n | output | 1 | Ready strobe, active low |
| ev_halt | output | 1 | Halt cycle pulse |
| ev_shutdown | output | 1 | Shutdown cycle pulse |
| ev_stopgrant | output | 1 | Stop grant cycle pulse |
| ev_flushack | output | 1 | Flush acknowledge cycle pulse |
| ev_writeback | output | 1 | Writeback cycle pulse |
| ev_cacheflush | output | 1 | Cache flush cycle pulse |
| ev_unknown | output | 1 | Unrecognised special cycle pulse |
| shutdown_flag | output | 1 | Sticky shutdown indication |

## Verification
The hardest situation to reach is a release input that coincides with the edge issuing a shutdown pulse. The bench starts a shutdown cycle with one wait clock and raises nmi in the gap clock, so that nmi is sampled exactly at the edge that fires. A close second is a strobe held low through the whole wait window and across the ready edge: the bench keeps ads_n low with a shutdown encoding behind a halt cycle. It then confirms that only the halt pulse appears and that the flag stays clear.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic [2:0] {
    SK_HALT   = 3'd0,
    SK_SHUT   = 3'd1,
    SK_STOPG  = 3'd2,
    SK_FLACK  = 3'd3,
    SK_WB     = 3'd4,
    SK_CFLUSH = 3'd5,
    SK_UNK    = 3'd6
  } spc_kind_e;

  localparam int NUM_KINDS = 7;
endpackage

// File: rtl/spc_classify.sv
module spc_classify
  import spc_pkg::*;
#(
  parameter int AW  = 32,
  parameter int ALO = 3,
  parameter int BEW = 8,
  parameter logic [BEW-1:0] BE_HALT_STOPG = 8'hFB,
  parameter logic [BEW-1:0] BE_SHUT       = 8'hFE,
  parameter logic [BEW-1:0] BE_FLACK      = 8'hEF,
  parameter logic [BEW-1:0] BE_WB         = 8'hF7,
  parameter logic [BEW-1:0] BE_CFLUSH     = 8'hFD,
  parameter logic [1:0]     SEL_BASE      = 2'b00,
  parameter logic [1:0]     SEL_STOPG     = 2'b10
) (
  input  logic [BEW-1:0]    be_n,
  input  logic [AW-1:ALO]   addr,
  output spc_kind_e         kind
);
  localparam int UPPER_LO = ALO + 2;
  localparam int UPPER_W  = AW - UPPER_LO;

  logic [UPPER_W-1:0] upper;
  logic [1:0]         sel;
  logic               upper_zero;
  logic               sel_base;

  assign upper      = addr[AW-1:UPPER_LO];
  assign sel        = addr[ALO+1:ALO];
  assign upper_zero = (upper == '0);
  assign sel_base   = (sel == SEL_BASE);

  always_comb begin
    kind = SK_UNK;
    if (upper_zero) begin
      if (be_n == BE_HALT_STOPG) begin
        if (sel_base)              kind = SK_HALT;
        else if (sel == SEL_STOPG) kind = SK_STOPG;
      end else if (be_n == BE_SHUT) begin
        if (sel_base) kind = SK_SHUT;
      end else if (be_n == BE_FLACK) begin
        if (sel_base) kind = SK_FLACK;
      end else if (be_n == BE_WB) begin
        if (sel_base) kind = SK_WB;
      end else if (be_n == BE_CFLUSH) begin
        if (sel_base) kind = SK_CFLUSH;
      end
    end
  end
endmodule

// File: rtl/spc_ready_timer.sv
module spc_ready_timer #(
  parameter int WW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [WW-1:0] wait_in,
  output logic          accept,
  output logic          fire_now,
  output logic          fire_q
);
  logic [WW-1:0] cnt;
  logic          busy;

  // A strobe is taken only when no cycle is pending and no ready is on the bus
  assign accept   = start && !busy && !fire_q;
  assign fire_now = (accept && (wait_in == '0)) || (busy && (cnt == WW'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= fire_now;
      if (accept && (wait_in != '0)) begin
        busy <= 1'b1;
        cnt  <= wait_in;
      end else if (busy) begin
        cnt <= cnt - WW'(1);
        if (cnt == WW'(1)) busy <= 1'b0;
      end
    end
  end

  // R6: ready lasts a single clock
  assert_ready_single_R6: assert property (@(posedge clk) disable iff (rst)
    fire_q |=> !fire_q);

  // R8: no new cycle is taken while the ready clock is on the bus
  assert_no_accept_in_ready_R8: assert property (@(posedge clk) disable iff (rst)
    fire_q |-> !accept);
endmodule

// File: rtl/spc_event_out.sv
module spc_event_out
  import spc_pkg::*;
#(
  parameter int NK = NUM_KINDS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire_now,
  input  spc_kind_e     kind,
  output logic [NK-1:0] ev_q
);
  for (genvar g = 0; g < NK; g++) begin : g_ev
    always_ff @(posedge clk) begin
      if (rst) ev_q[g] <= 1'b0;
      else     ev_q[g] <= fire_now && (kind == spc_kind_e'(g));
    end
  end

  // R7: at most one event at a time
  assert_event_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ev_q));
endmodule

// File: rtl/spc_shutdown_latch.sv
module spc_shutdown_latch (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R9: a shutdown pulse always leaves the flag set
  assert_flag_sets_R9: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);

  // R9: the flag only drops after a release input
  assert_flag_release_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(clr));
endmodule

// File: rtl/spc_cycle_watch.sv
module spc_cycle_watch
  import spc_pkg::*;
#(
  parameter int AW  = 32,
  parameter int ALO = 3,
  parameter int BEW = 8,
  parameter int WW  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ads_n,
  input  logic            dc_n,
  input  logic            mio_n,
  input  logic            wr_n,
  input  logic [BEW-1:0]  be_n,
  input  logic [AW-1:ALO] addr,
  input  logic [WW-1:0]   wait_cfg,
  input  logic            nmi,
  input  logic            init,
  input  logic            smi_n,
  output logic            brdy_n,
  output logic            ev_halt,
  output logic            ev_shutdown,
  output logic            ev_stopgrant,
  output logic            ev_flushack,
  output logic            ev_writeback,
  output logic            ev_cacheflush,
  output logic            ev_unknown,
  output logic            shutdown_flag
);
  localparam int NK = NUM_KINDS;

  logic          is_special;
  logic          accept;
  logic          fire_now;
  logic          fire_q;
  spc_kind_e     kind_dec;
  spc_kind_e     kind_held;
  spc_kind_e     kind_fire;
  logic [NK-1:0] ev_vec;
  logic          release_req;

  assign is_special = !ads_n && !dc_n && !mio_n && wr_n;

  spc_classify #(.AW(AW), .ALO(ALO), .BEW(BEW)) u_cls (
    .be_n (be_n),
    .addr (addr),
    .kind (kind_dec)
  );

  spc_ready_timer #(.WW(WW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .start    (is_special),
    .wait_in  (wait_cfg),
    .accept   (accept),
    .fire_now (fire_now),
    .fire_q   (fire_q)
  );

  always_ff @(posedge clk) begin
    if (rst)         kind_held <= SK_UNK;
    else if (accept) kind_held <= kind_dec;
  end

  // A zero-wait cycle fires on the edge that decodes it
  assign kind_fire = accept ? kind_dec : kind_held;

  spc_event_out #(.NK(NK)) u_ev (
    .clk      (clk),
    .rst      (rst),
    .fire_now (fire_now),
    .kind     (kind_fire),
    .ev_q     (ev_vec)
  );

  assign release_req = nmi || init || !smi_n;

  spc_shutdown_latch u_sd (
    .clk  (clk),
    .rst  (rst),
    .set  (fire_now && (kind_fire == SK_SHUT)),
    .clr  (release_req),
    .flag (shutdown_flag)
  );

  assign brdy_n        = !fire_q;
  assign ev_halt       = ev_vec[SK_HALT];
  assign ev_shutdown   = ev_vec[SK_SHUT];
  assign ev_stopgrant  = ev_vec[SK_STOPG];
  assign ev_flushack   = ev_vec[SK_FLACK];
  assign ev_writeback  = ev_vec[SK_WB];
  assign ev_cacheflush = ev_vec[SK_CFLUSH];
  assign ev_unknown    = ev_vec[SK_UNK];

  // R7: every ready carries exactly one event
  assert_ready_has_event_R7: assert property (@(posedge clk) disable iff (rst)
    !brdy_n |-> ($countones(ev_vec) == 1));

  // R7: no event outside the ready clock
  assert_event_needs_ready_R7: assert property (@(posedge clk) disable iff (rst)
    (|ev_vec) |-> !brdy_n);

  // R9: shutdown pulse and flag appear together
  assert_flag_with_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    ev_shutdown |-> shutdown_flag);
endmodule

// File: tb/sim_spc_cycle_watch.sv
`timescale 1ns/1ps
module sim_spc_cycle_watch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ads_n = 1'b1, dc_n = 1'b1, mio_n = 1'b1, wr_n = 1'b0;
  logic [7:0]  be_n = 8'hFF;
  logic [31:3] addr = '0;
  logic [1:0]  wait_cfg = 2'd0;
  logic        nmi = 1'b0, init = 1'b0, smi_n = 1'b1;
  logic        brdy_n, ev_halt, ev_shutdown, ev_stopgrant, ev_flushack;
  logic        ev_writeback, ev_cacheflush, ev_unknown, shutdown_flag;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  localparam logic [6:0] E_NONE = 7'b0000000, E_HALT = 7'b0000001, E_SHUT = 7'b0000010,
    E_STOPG = 7'b0000100, E_FLACK = 7'b0001000, E_WB = 7'b0010000,
    E_CFL = 7'b0100000, E_UNK = 7'b1000000;

  always #10 clk = ~clk;

  spc_cycle_watch u0 (
    .clk(clk), .rst(rst), .ads_n(ads_n), .dc_n(dc_n), .mio_n(mio_n), .wr_n(wr_n),
    .be_n(be_n), .addr(addr), .wait_cfg(wait_cfg), .nmi(nmi), .init(init), .smi_n(smi_n),
    .brdy_n(brdy_n), .ev_halt(ev_halt), .ev_shutdown(ev_shutdown), .ev_stopgrant(ev_stopgrant),
    .ev_flushack(ev_flushack), .ev_writeback(ev_writeback), .ev_cacheflush(ev_cacheflush),
    .ev_unknown(ev_unknown), .shutdown_flag(shutdown_flag));

  function automatic logic [6:0] evs();
    return {ev_unknown, ev_cacheflush, ev_writeback, ev_flushack, ev_stopgrant, ev_shutdown, ev_halt};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    ads_n = 1'b1; dc_n = 1'b1; mio_n = 1'b1; wr_n = 1'b0; be_n = 8'hFF; addr = '0;
  endtask

  // Drive one cycle at a negedge; check ready timing and the event set
  task automatic do_cycle(input logic [7:0] be, input logic [1:0] sel, input logic [26:0] up,
                          input logic [1:0] w, input logic [6:0] exp_ev, input string req);
    @(negedge clk);
    ads_n = 1'b0; dc_n = 1'b0; mio_n = 1'b0; wr_n = 1'b1;
    be_n = be; addr = {up, sel}; wait_cfg = w;
    @(posedge clk);
    for (int j = 0; j <= int'(w); j++) begin
      @(negedge clk);
      if (j == 0) idle_bus();
      if (j == int'(w)) begin
        chk(brdy_n == 1'b0, {req, " R6 ready low"}, brdy_n, 0);
        chk(evs() == exp_ev, {req, " event"}, evs(), exp_ev);
      end else begin
        chk(brdy_n == 1'b1 && evs() == E_NONE, {req, " R6 early ready"}, brdy_n, 1);
      end
    end
    @(negedge clk);
    chk(brdy_n == 1'b1 && evs() == E_NONE, {req, " R7 single pulse"}, {brdy_n, evs()}, 8'h80);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(brdy_n == 1'b1 && evs() == E_NONE && shutdown_flag == 1'b0, "R10 reset state",
        {brdy_n, evs(), shutdown_flag}, 9'h100);
  endtask

  task automatic t_decode();
    do_cycle(8'hFB, 2'b00, 27'd0, 2'd0, E_HALT,  "R2 halt");
    do_cycle(8'hFB, 2'b10, 27'd0, 2'd1, E_STOPG, "R2 stop grant");
    do_cycle(8'hEF, 2'b00, 27'd0, 2'd2, E_FLACK, "R3 flush ack");
    do_cycle(8'hF7, 2'b00, 27'd0, 2'd3, E_WB,    "R3 writeback");
    do_cycle(8'hFD, 2'b00, 27'd0, 2'd1, E_CFL,   "R3 cache flush");
  endtask

  task automatic t_unknown();
    do_cycle(8'hFF, 2'b00, 27'd0, 2'd0, E_UNK, "R5 byte enables");
    do_cycle(8'hFB, 2'b01, 27'd0, 2'd2, E_UNK, "R5 select 01");
    do_cycle(8'hEF, 2'b10, 27'd0, 2'd0, E_UNK, "R5 select 10 on flush ack");
    do_cycle(8'hFB, 2'b00, 27'h0400000, 2'd1, E_UNK, "R5 upper address");
  endtask

  task automatic t_not_special();
    logic [2:0] q;
    for (int k = 0; k < 7; k++) begin
      q = 3'(k);
      @(negedge clk);
      ads_n = 1'b0; dc_n = q[0]; mio_n = q[1]; wr_n = ~q[2]; be_n = 8'hFB; addr = '0;
      wait_cfg = 2'd0;
      if (k == 0) ads_n = 1'b1;
      @(negedge clk);
      idle_bus();
      chk(brdy_n == 1'b1 && evs() == E_NONE, "R1 non-special ignored", {brdy_n, evs()}, 8'h80);
    end
  endtask

  task automatic t_overlap();
    @(negedge clk);
    ads_n = 1'b0; dc_n = 1'b0; mio_n = 1'b0; wr_n = 1'b1; be_n = 8'hFB; addr = '0; wait_cfg = 2'd3;
    @(posedge clk);
    @(negedge clk);
    be_n = 8'hFE; wait_cfg = 2'd0;   // keep strobing a shutdown through E1..E3
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(brdy_n == 1'b0 && evs() == E_HALT, "R8 only first cycle served", evs(), E_HALT);
    idle_bus();
    @(negedge clk);
    chk(brdy_n == 1'b1 && evs() == E_NONE, "R8 no second ready", {brdy_n, evs()}, 8'h80);
    chk(shutdown_flag == 1'b0, "R8 ignored strobe left flag clear", shutdown_flag, 0);
  endtask

  task automatic t_shutdown();
    // set by cycle, hold, then release by each input
    for (int r = 0; r < 3; r++) begin
      do_cycle(8'hFE, 2'b00, 27'd0, 2'(r), E_SHUT, "R4 shutdown");
      chk(shutdown_flag == 1'b1, "R9 flag held", shutdown_flag, 1);
      @(negedge clk);
      chk(shutdown_flag == 1'b1, "R9 flag sticky", shutdown_flag, 1);
      if (r == 0) nmi = 1'b1; else if (r == 1) init = 1'b1; else smi_n = 1'b0;
      @(negedge clk);
      nmi = 1'b0; init = 1'b0; smi_n = 1'b1;
      chk(shutdown_flag == 1'b0, "R9 flag released", shutdown_flag, 0);
    end
    // release input on the firing edge: set wins
    @(negedge clk);
    ads_n = 1'b0; dc_n = 1'b0; mio_n = 1'b0; wr_n = 1'b1; be_n = 8'hFE; addr = '0; wait_cfg = 2'd1;
    @(negedge clk);
    idle_bus();
    nmi = 1'b1;
    @(negedge clk);
    nmi = 1'b0;
    chk(ev_shutdown == 1'b1 && shutdown_flag == 1'b1, "R9 set wins over release",
        shutdown_flag, 1);
    // reset clears the flag
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(shutdown_flag == 1'b0 && brdy_n == 1'b1, "R10 reset clears flag", shutdown_flag, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_decode();
    t_unknown();
    t_not_special();
    t_overlap();
    t_shutdown();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule